// File: doc/BRIEF.md
# Interrupt Route Map Controller

This block keeps, for every interrupt line, the number of the core that should service it, and lets software rewrite those destinations four at a time. A 32-bit write to the route window carries one byte per interrupt: byte lane i, counting from the least significant byte, sets the destination of interrupt `base + i`. `base` is the word-aligned byte offset of the write. A route byte is decoded in one of two ways. In the default mode the byte is a bitmap, and the lowest set bit names one of the first four cores. In the encoded mode the byte value is the core number itself, so all 256 cores can be reached.

The mode is held in a status word in a small extension window. The same window holds a read-only feature word, which advertises what the status word may contain. Software can only enable advertised features, and it cannot reconfigure the block while the enable bit is on, except by writing zero. When the block is built without the extension, the window answers every access with an error and the block always behaves as enabled in bitmap mode.

Every destination that actually changes is reported downstream with a one-cycle strobe per byte lane, together with the interrupt number and the new core number. A combinational lookup port returns the stored destination of any interrupt.

Top module: `irq_route_map`

## Requirements
- R1: Each cycle with `req_valid` high produces exactly one response: `rsp_valid` is high on the following cycle and low after a cycle without a request.
- R2: A route access has `req_addr[8]` = 0. The four entries addressed are `req_addr[7:0]` with its two low bits cleared, plus 0 to 3. The two low bits have no effect.
- R3: In bitmap mode (status bit 1 clear), a route byte decodes to the index of its lowest set bit. When bits 0 to 3 of the byte are all clear, it decodes to core 0.
- R4: In encoded mode (status bit 1 set), a route byte decodes to its own value as the core number.
- R5: One cycle after a route write, `chg_strobe[i]` pulses exactly for the lanes whose decoded destination differs from the stored one. `chg_irq` and `chg_core` for that lane give the interrupt and its new core. An unchanged entry produces no strobe.
- R6: A route read returns the four stored destinations, with byte i holding entry `base + i`.
- R7: In the extension window (`req_addr[8]` = 1, `req_addr[2]` = 0) the feature word reads as 0x7: bit 0 enable, bit 1 encoded mode, bit 2 extension present. A write to it returns an error and changes nothing.
- R8: An accepted write to the status word (`req_addr[8]` = 1, `req_addr[2]` = 1) stores the written value ANDed with the feature word. A read returns the status word.
- R9: A status write with a nonzero value while status bit 0 (enable) is set returns an error and leaves the status word unchanged. A zero write is always accepted.
- R10: Reset clears the status word and every route entry to 0, and no strobe or response is active.
- R11: Without the extension, every access to the extension window returns an error with read data 0, and route bytes are always decoded in bitmap mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Byte address; bit 8 selects the extension window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_err | output | 1 | Access refused |
| rsp_rdata | output | 32 | Read data (0 for writes and refused accesses) |
| chg_strobe | output | 4 | Per-lane destination-changed pulse |
| chg_irq | output | 32 | Per-lane interrupt number, 8 bits per lane |
| chg_core | output | 32 | Per-lane new core number, 8 bits per lane |
| lookup_irq | input | 8 | Interrupt to look up |
| lookup_core | output | 8 | Stored destination of `lookup_irq` |

## Verification
Responses and change strobes come from registers loaded on the clock edge after the request. The bench drives each request just after a falling edge and releases it one full cycle later, then samples `rsp_*` and `chg_*` at that second falling edge, where both are due. The table is updated on the same edge, so the lookup port is read afterwards while the bus is idle, and `rsp_valid` is sampled low one cycle later. Both decode modes are swept over all 256 byte values against a bench model of the table.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   localparam int LANES  = 4;
   localparam int BYTE_W = 8;
   localparam int WORD_W = LANES * BYTE_W;

   // status / feature bit positions (status = written value & features)
   localparam int ST_EN   = 0;
   localparam int ST_ENC  = 1;
   localparam int ST_VEXT = 2;

   localparam logic [WORD_W-1:0] FEAT_FULL =
      WORD_W'((1 << ST_EN) | (1 << ST_ENC) | (1 << ST_VEXT));
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
   import irq_route_pkg::*;
#(
   parameter int CORE_W       = 8,
   parameter int BITMAP_CORES = 4
) (
   input  logic [BYTE_W-1:0] route_byte,
   input  logic              enc_mode,
   output logic [CORE_W-1:0] core
);
   if (BITMAP_CORES < 1 || BITMAP_CORES > BYTE_W)
      $error("BITMAP_CORES must lie in 1..8");
   if (CORE_W < BYTE_W)
      $error("CORE_W must hold a full route byte");

   logic [CORE_W-1:0] bitmap_core;

   always_comb begin
      logic hit;
      hit         = 1'b0;
      bitmap_core = '0;
      for (int i = 0; i < BITMAP_CORES; i++) begin
         if (!hit && route_byte[i]) begin
            bitmap_core = CORE_W'(i);
            hit         = 1'b1;
         end
      end
   end

   assign core = enc_mode ? CORE_W'(route_byte) : bitmap_core;

   always_comb begin
      if (enc_mode == 1'b0) begin
         a_r3_bitmap_range: assert (core < CORE_W'(BITMAP_CORES));
      end
   end
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
   import irq_route_pkg::*;
#(
   parameter int NUM_IRQ = 256,
   parameter int CORE_W  = 8,
   localparam int IRQ_W  = $clog2(NUM_IRQ)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [IRQ_W-1:0]        wr_base,
   input  logic [LANES*CORE_W-1:0] wr_core,
   output logic [LANES*CORE_W-1:0] rd_word,
   input  logic [IRQ_W-1:0]        lk_idx,
   output logic [CORE_W-1:0]       lk_core,
   output logic [LANES-1:0]        chg_strobe,
   output logic [LANES*IRQ_W-1:0]  chg_irq,
   output logic [LANES*CORE_W-1:0] chg_core
);
   if (NUM_IRQ < 2 * LANES || (1 << IRQ_W) != NUM_IRQ)
      $error("NUM_IRQ must be a power of two of at least 8");

   logic [CORE_W-1:0] mem [NUM_IRQ];
   logic [IRQ_W-1:0]  lane_idx [LANES];
   logic [CORE_W-1:0] lane_new [LANES];
   logic [CORE_W-1:0] lane_old [LANES];
   logic [LANES-1:0]  lane_diff;
   logic [1:0]        unused_base_low;

   assign unused_base_low = wr_base[1:0];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_idx[i] = {wr_base[IRQ_W-1:2], 2'(i)};
      assign lane_new[i] = wr_core[i*CORE_W +: CORE_W];
      assign lane_old[i] = mem[lane_idx[i]];
      assign lane_diff[i] = wr_en && (lane_new[i] != lane_old[i]);
      assign rd_word[i*CORE_W +: CORE_W] =
         mem[{wr_base[IRQ_W-1:2], 2'(i)}];

      a_r5_strobe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
         chg_strobe[i] |-> $past(wr_en));
      a_r5_strobe_real_change: assert property (@(posedge clk) disable iff (!rst_n)
         chg_strobe[i] |-> ($past(lane_old[i]) != chg_core[i*CORE_W +: CORE_W]));
      a_r5_entry_holds_new: assert property (@(posedge clk) disable iff (!rst_n)
         chg_strobe[i] |-> (mem[chg_irq[i*IRQ_W +: IRQ_W]] == chg_core[i*CORE_W +: CORE_W]));
   end

   assign lk_core = mem[lk_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < NUM_IRQ; e++) mem[e] <= '0;
         chg_strobe <= '0;
         chg_irq    <= '0;
         chg_core   <= '0;
      end else begin
         chg_strobe <= lane_diff;
         for (int l = 0; l < LANES; l++) begin
            if (lane_diff[l]) begin
               mem[lane_idx[l]]               <= lane_new[l];
               chg_irq[l*IRQ_W +: IRQ_W]      <= lane_idx[l];
               chg_core[l*CORE_W +: CORE_W]   <= lane_new[l];
            end
         end
      end
   end
endmodule

// File: rtl/irq_route_ext.sv
module irq_route_ext
   import irq_route_pkg::*;
#(
   parameter bit HAS_VEXT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_sel,
   input  logic              ext_write,
   input  logic              ext_cfg,
   input  logic [WORD_W-1:0] wdata,
   output logic              ext_err,
   output logic [WORD_W-1:0] ext_rdata,
   output logic [WORD_W-1:0] status
);
   if (HAS_VEXT) begin : g_vext
      localparam logic [WORD_W-1:0] FEATURES = FEAT_FULL;
      logic [WORD_W-1:0] status_q;
      logic              refuse;
      logic              accept_cfg;

      assign refuse = ext_write &&
                      (!ext_cfg || (status_q[ST_EN] && (wdata != '0)));
      assign accept_cfg = ext_sel && ext_write && ext_cfg && !refuse;
      assign ext_err    = ext_sel && refuse;
      assign ext_rdata  = (!ext_sel || ext_write) ? '0 :
                          (ext_cfg ? status_q : FEATURES);
      assign status     = status_q;

      always_ff @(posedge clk) begin
         if (!rst_n)          status_q <= '0;
         else if (accept_cfg) status_q <= wdata & FEATURES;
      end

      a_r8_status_advertised: assert property (@(posedge clk) disable iff (!rst_n)
         (status_q & ~FEATURES) == '0);
      a_r9_locked_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
         (ext_sel && ext_write && ext_cfg && status_q[ST_EN] && wdata != '0)
         |=> $stable(status_q));
      a_r7_feature_write_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
         (ext_sel && ext_write && !ext_cfg) |=> $stable(status_q));
   end else begin : g_novext
      logic unused_ext_inputs;
      assign unused_ext_inputs = ^{clk, rst_n, ext_write, ext_cfg, wdata};
      assign ext_err   = ext_sel;
      assign ext_rdata = '0;
      assign status    = WORD_W'(1 << ST_EN);
   end
endmodule

// File: rtl/irq_route_map.sv
module irq_route_map
   import irq_route_pkg::*;
#(
   parameter int  NUM_IRQ      = 256,
   parameter int  CORE_W       = 8,
   parameter int  BITMAP_CORES = 4,
   parameter bit  HAS_VEXT     = 1'b1,
   localparam int IRQ_W        = $clog2(NUM_IRQ),
   localparam int ADDR_W       = IRQ_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic                    req_write,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [WORD_W-1:0]       req_wdata,
   output logic                    rsp_valid,
   output logic                    rsp_err,
   output logic [WORD_W-1:0]       rsp_rdata,
   output logic [LANES-1:0]        chg_strobe,
   output logic [LANES*IRQ_W-1:0]  chg_irq,
   output logic [LANES*CORE_W-1:0] chg_core,
   input  logic [IRQ_W-1:0]        lookup_irq,
   output logic [CORE_W-1:0]       lookup_core
);
   if (CORE_W != BYTE_W)
      $error("route bytes carry 8-bit core numbers; CORE_W must be 8");
   if (IRQ_W < 3)
      $error("extension window decode needs an address of at least 4 bits");

   logic                    ext_win;
   logic                    route_sel;
   logic                    ext_sel;
   logic [IRQ_W-1:0]        base;
   logic [WORD_W-1:0]       status;
   logic                    ext_err;
   logic [WORD_W-1:0]       ext_rdata;
   logic [LANES*CORE_W-1:0] dec_core;
   logic [LANES*CORE_W-1:0] rd_word;
   logic [1:0]              unused_addr_low;

   assign ext_win   = req_addr[ADDR_W-1];
   assign route_sel = req_valid && !ext_win;
   assign ext_sel   = req_valid && ext_win;
   assign base      = {req_addr[IRQ_W-1:2], 2'b00};
   assign unused_addr_low = req_addr[1:0];

   for (genvar i = 0; i < LANES; i++) begin : g_dec
      irq_route_decode #(
         .CORE_W       (CORE_W),
         .BITMAP_CORES (BITMAP_CORES)
      ) u_dec (
         .route_byte (req_wdata[i*BYTE_W +: BYTE_W]),
         .enc_mode   (status[ST_ENC]),
         .core       (dec_core[i*CORE_W +: CORE_W])
      );
   end

   irq_route_table #(
      .NUM_IRQ (NUM_IRQ),
      .CORE_W  (CORE_W)
   ) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (route_sel && req_write),
      .wr_base    (base),
      .wr_core    (dec_core),
      .rd_word    (rd_word),
      .lk_idx     (lookup_irq),
      .lk_core    (lookup_core),
      .chg_strobe (chg_strobe),
      .chg_irq    (chg_irq),
      .chg_core   (chg_core)
   );

   irq_route_ext #(
      .HAS_VEXT (HAS_VEXT)
   ) u_ext (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_sel   (ext_sel),
      .ext_write (req_write),
      .ext_cfg   (req_addr[2]),
      .wdata     (req_wdata),
      .ext_err   (ext_err),
      .ext_rdata (ext_rdata),
      .status    (status)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= ext_sel && ext_err;
         if (route_sel && !req_write) rsp_rdata <= WORD_W'(rd_word);
         else if (ext_sel)            rsp_rdata <= ext_rdata;
         else                         rsp_rdata <= '0;
      end
   end

   a_r1_response_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r1_no_spurious_response: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   a_r7_feature_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_sel && req_write && !req_addr[2]) |=> rsp_err);
   a_r2_route_never_errs: assert property (@(posedge clk) disable iff (!rst_n)
      route_sel |=> !rsp_err);
   a_r5_no_strobe_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !(route_sel && req_write) |=> (chg_strobe == '0));

   if (!HAS_VEXT) begin : g_chk_novext
      a_r11_window_absent: assert property (@(posedge clk) disable iff (!rst_n)
         ext_sel |=> (rsp_err && rsp_rdata == '0));
   end
endmodule

// File: tb/irq_route_map_bench.sv
module irq_route_map_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [8:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic [3:0]  chg_strobe;
   logic [31:0] chg_irq, chg_core;
   logic [7:0]  lookup_irq = '0;
   logic [7:0]  lookup_core;

   logic        n_valid = 1'b0, n_write = 1'b0;
   logic [8:0]  n_addr = '0;
   logic [31:0] n_wdata = '0;
   logic        n_rsp_valid, n_rsp_err;
   logic [31:0] n_rsp_rdata;
   logic [3:0]  n_strobe;
   logic [31:0] n_irq, n_core;
   logic [7:0]  n_lookup_irq = '0;
   logic [7:0]  n_lookup_core;

   irq_route_map u_irq_route_map (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .chg_strobe(chg_strobe),
      .chg_irq(chg_irq), .chg_core(chg_core), .lookup_irq(lookup_irq),
      .lookup_core(lookup_core));

   irq_route_map #(.HAS_VEXT(1'b0)) u_noext (
      .clk(clk), .rst_n(rst_n), .req_valid(n_valid), .req_write(n_write),
      .req_addr(n_addr), .req_wdata(n_wdata), .rsp_valid(n_rsp_valid),
      .rsp_err(n_rsp_err), .rsp_rdata(n_rsp_rdata), .chg_strobe(n_strobe),
      .chg_irq(n_irq), .chg_core(n_core), .lookup_irq(n_lookup_irq),
      .lookup_core(n_lookup_core));

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;
   logic [7:0] model [256];

   logic        s_valid, s_err;
   logic [31:0] s_rdata;
   logic [3:0]  s_strobe;
   logic [31:0] s_irq, s_core;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] ref_bitmap(input logic [7:0] b);
      for (int i = 0; i < 4; i++) if (b[i]) return 8'(i);
      return 8'd0;
   endfunction

   task automatic access(input bit wr, input logic [8:0] addr, input logic [31:0] data);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      s_valid = rsp_valid; s_err = rsp_err; s_rdata = rsp_rdata;
      s_strobe = chg_strobe; s_irq = chg_irq; s_core = chg_core;
      chk(s_valid === 1'b1, "R1 response valid", s_valid, 1);
   endtask

   task automatic n_access(input bit wr, input logic [8:0] addr, input logic [31:0] data);
      @(negedge clk);
      n_valid = 1'b1; n_write = wr; n_addr = addr; n_wdata = data;
      @(negedge clk);
      n_valid = 1'b0; n_write = 1'b0;
      s_valid = n_rsp_valid; s_err = n_rsp_err; s_rdata = n_rsp_rdata;
      s_strobe = n_strobe;
   endtask

   // one route write, checked lane by lane against the model
   task automatic route_write(input logic [8:0] addr, input logic [31:0] data,
                              input bit enc, input string req);
      logic [7:0] base;
      logic [7:0] dest [4];
      logic [3:0] exp_strobe;
      base = {addr[7:2], 2'b00};
      for (int i = 0; i < 4; i++) begin
         dest[i] = enc ? data[i*8 +: 8] : ref_bitmap(data[i*8 +: 8]);
         exp_strobe[i] = (dest[i] != model[base + 8'(i)]);
      end
      access(1'b1, addr, data);
      chk(s_err === 1'b0, "R2 route write no error", s_err, 0);
      chk(s_strobe === exp_strobe, {"R5 strobes ", req}, s_strobe, exp_strobe);
      for (int i = 0; i < 4; i++) begin
         if (exp_strobe[i]) begin
            chk(s_irq[i*8 +: 8] === base + 8'(i), "R5 chg_irq", s_irq[i*8 +: 8], base + 8'(i));
            chk(s_core[i*8 +: 8] === dest[i], {"R5 chg_core ", req}, s_core[i*8 +: 8], dest[i]);
         end
         model[base + 8'(i)] = dest[i];
         lookup_irq = base + 8'(i);
         #1;
         chk(lookup_core === dest[i], {"R2 entry ", req}, lookup_core, dest[i]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int e = 0; e < 256; e++) model[e] = 8'd0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(rsp_valid === 1'b0, "R10 rsp_valid after reset", rsp_valid, 0);
      chk(chg_strobe === 4'd0, "R10 strobes after reset", chg_strobe, 0);
      lookup_irq = 8'd0;   #1; chk(lookup_core === 8'd0, "R10 entry 0", lookup_core, 0);
      lookup_irq = 8'd255; #1; chk(lookup_core === 8'd0, "R10 entry 255", lookup_core, 0);
      access(1'b0, 9'h104, 32'h0);
      chk(s_rdata === 32'h0 && !s_err, "R10 status cleared", s_rdata, 0);
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R1 idle no response", rsp_valid, 0);

      // R7 feature word
      access(1'b0, 9'h100, 32'h0);
      chk(s_rdata === 32'h7 && !s_err, "R7 feature read", s_rdata, 7);
      access(1'b1, 9'h100, 32'h0);
      chk(s_err === 1'b1, "R7 feature write refused", s_err, 1);
      access(1'b0, 9'h100, 32'h0);
      chk(s_rdata === 32'h7, "R7 feature unchanged", s_rdata, 7);
      access(1'b0, 9'h104, 32'h0);
      chk(s_rdata === 32'h0, "R7 status untouched by feature write", s_rdata, 0);

      // R3 bitmap sweep, low address bits varied (R2)
      for (int v = 0; v < 256; v++) begin
         logic [31:0] w;
         for (int i = 0; i < 4; i++) w[i*8 +: 8] = 8'(v + i * 64);
         route_write(9'((v * 4 + v % 4) % 256), w, 1'b0, "R3 bitmap");
      end

      // R6 route read
      for (int b = 0; b < 256; b += 52) begin
         logic [31:0] exp_w;
         for (int i = 0; i < 4; i++) exp_w[i*8 +: 8] = model[b + i];
         access(1'b0, 9'(b + 1), 32'h0);
         chk(s_rdata === exp_w && !s_err, "R6 route read", s_rdata, exp_w);
      end

      // R5 rewrite with equal destinations: no strobes
      begin
         logic [31:0] same;
         for (int i = 0; i < 4; i++) same[i*8 +: 8] = 8'(1 << model[8 + i]);
         route_write(9'd8, same, 1'b0, "R5 unchanged rewrite");
      end

      // R8 status writes masked by features
      access(1'b1, 9'h104, 32'hFFFF_FFF2);
      chk(!s_err, "R8 status write accepted", s_err, 0);
      access(1'b0, 9'h104, 32'h0);
      chk(s_rdata === 32'h2, "R8 status masked", s_rdata, 2);
      access(1'b1, 9'h104, 32'h3);
      access(1'b0, 9'h104, 32'h0);
      chk(s_rdata === 32'h3, "R8 status enable+encoded", s_rdata, 3);
      // R9 locked while enabled
      access(1'b1, 9'h104, 32'h2);
      chk(s_err === 1'b1, "R9 nonzero write refused", s_err, 1);
      access(1'b0, 9'h104, 32'h0);
      chk(s_rdata === 32'h3, "R9 status unchanged", s_rdata, 3);

      // R4 encoded sweep
      for (int v = 0; v < 256; v++) begin
         logic [31:0] w;
         for (int i = 0; i < 4; i++) w[i*8 +: 8] = 8'(v * 7 + i * 61);
         route_write(9'((v * 4) % 256), w, 1'b1, "R4 encoded");
      end

      // R9 zero write accepted while enabled
      access(1'b1, 9'h104, 32'h0);
      chk(!s_err, "R9 zero write accepted", s_err, 0);
      access(1'b0, 9'h104, 32'h0);
      chk(s_rdata === 32'h0, "R9 status cleared", s_rdata, 0);
      route_write(9'd16, 32'h80_40_20_10, 1'b0, "R3 upper bits only");

      // R11 variant without extension
      n_access(1'b0, 9'h104, 32'h0);
      chk(s_valid === 1'b1 && s_err === 1'b1 && s_rdata === 32'h0,
          "R11 status read refused", {s_valid, s_err, s_rdata}, 34'h3_0000_0000);
      n_access(1'b1, 9'h104, 32'h2);
      chk(s_err === 1'b1, "R11 status write refused", s_err, 1);
      n_access(1'b0, 9'h100, 32'h0);
      chk(s_err === 1'b1 && s_rdata === 32'h0, "R11 feature read refused", s_rdata, 0);
      n_access(1'b1, 9'h000, 32'h08_F0_06_05);
      chk(s_strobe === 4'b1010, "R11 bitmap strobes", s_strobe, 4'b1010);
      for (int i = 0; i < 4; i++) begin
         logic [7:0] e;
         e = (i == 0) ? 8'd0 : (i == 1) ? 8'd1 : (i == 2) ? 8'd0 : 8'd3;
         n_lookup_irq = 8'(i); #1;
         chk(n_lookup_core === e, "R11 bitmap decode", n_lookup_core, e);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule